// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of an Ethernet-style controller. Software builds a ring of 8-byte buffer descriptors in system memory, sets the ring base, and pulses a kick input. The block then fetches each descriptor over a simple 32-bit request/acknowledge memory master and reads the referenced buffer one word at a time. It sends the buffer bytes out on a ready/valid byte stream that marks the end of each frame.

A frame may be spread over several descriptors, and its total size is capped. After a descriptor is consumed, the block clears its ownership bit, writes it back to memory, and moves to the next slot, either linearly or back to the ring base. The walk stops at the first descriptor that is not owned by the hardware, or after a fixed number of descriptors per kick. Single-cycle event pulses report each consumed buffer, each completed frame and each truncation.

Top module: `txring_dma`

## Requirements
- R1: After reset, no memory request is issued, the stream carries no valid byte and no event pulse is raised until a kick arrives.
- R2: A descriptor at pointer P holds a big-endian word at P with flags in bits 31:16 and length in bits 15:0, and the buffer address at P+4. Buffer bytes are streamed in ascending address order from any byte alignment. The byte at an address with offset 0 within its word is taken from bits 31:24. Every memory access is word-aligned.
- R3: If the fetched flags have bit 15 (hardware-owned) clear, the walk ends without changing the pointer. A later kick fetches that same descriptor address again.
- R4: When flags bit 13 (ring end) is set, the next descriptor is the ring base. Otherwise the pointer advances by 8.
- R5: Flags bit 11 closes the frame. The final byte of the frame carries the end-of-frame marker, and a frame-done pulse is raised. A closing descriptor of zero length puts the marker on the previous byte of the frame.
- R6: Each consumed descriptor is written back to its first word with bit 15 cleared and all other flag and length bits unchanged, and one buffer-done pulse is raised. A frame-done pulse always coincides with a buffer-done pulse.
- R7: A frame carries at most MAX_FRAME bytes. Bytes past the cap are dropped, and each descriptor that loses bytes raises one truncation pulse. The byte count restarts after every end-of-frame.
- R8: A kick while the enable input is low starts no memory activity.
- R9: One kick consumes at most MAX_DESC descriptors. A further kick resumes at the next descriptor.
- R10: A write to the ring base clears bits 1:0 of the written value and also loads the current descriptor pointer.
- R11: A kick that ends inside a frame emits no end-of-frame marker. The final byte so far is held back, and the frame continues with the next kick.
- R12: While the stream is valid and the sink is not ready, the byte and the marker stay stable. No byte is lost or duplicated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable; gates kicks |
| kick_i | input | 1 | Single-cycle request to walk the ring |
| base_we_i | input | 1 | Ring base write strobe |
| base_i | input | AW | Ring base value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | End-of-frame marker |
| tx_ready_i | input | 1 | Stream sink ready |
| ev_txb_o | output | 1 | Buffer-done pulse |
| ev_txf_o | output | 1 | Frame-done pulse |
| ev_babt_o | output | 1 | Truncation pulse |

## Verification
The properties assume that the memory raises an acknowledge only against a pending request, for exactly one cycle, with read data valid in that cycle. They also assume the sink never asks for a byte to be withdrawn. The bench memory model acknowledges each request once, one cycle after it appears, and the sink ready follows a pseudo-random pattern only during the backpressure scenario. Kicks are single-cycle, and every descriptor and buffer lies inside the modelled memory. The ring base is rewritten only while the walker is idle, so the pointer checks depend on the walk alone.

// File: rtl/txring_pkg.sv
package txring_pkg;
   // descriptor flag bit positions (within the 16-bit flags half)
   localparam int unsigned BIT_OWN  = 15;
   localparam int unsigned BIT_WRAP = 13;
   localparam int unsigned BIT_EOF  = 11;
   localparam int unsigned DESC_BYTES = 8;
   localparam int unsigned PTR_OFS    = 4;

   typedef enum logic [2:0] {
      S_IDLE,
      S_HDR,
      S_PTR,
      S_RD,
      S_EMIT,
      S_CLOSE,
      S_WB
   } walk_st_t;
endpackage

// File: rtl/txring_lane.sv
module txring_lane #(
   parameter int BIG_END = 1
) (
   input  logic [31:0] word_i,
   input  logic [1:0]  off_i,
   output logic [7:0]  byte_o
);
   generate
      if (BIG_END != 0) begin : g_be
         always_comb begin
            case (off_i)
               2'd0:    byte_o = word_i[31:24];
               2'd1:    byte_o = word_i[23:16];
               2'd2:    byte_o = word_i[15:8];
               default: byte_o = word_i[7:0];
            endcase
         end
      end else begin : g_le
         always_comb begin
            case (off_i)
               2'd0:    byte_o = word_i[7:0];
               2'd1:    byte_o = word_i[15:8];
               2'd2:    byte_o = word_i[23:16];
               default: byte_o = word_i[31:24];
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/txring_outq.sv
// One-byte hold stage plus output register. The hold stage keeps the newest
// byte back until it is known whether the frame closes after it.
module txring_outq #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          flush_i,
   input  logic [DW-1:0] byte_i,
   output logic          accept_o,
   input  logic          tx_ready_i,
   output logic          tx_valid_o,
   output logic [DW-1:0] tx_data_o,
   output logic          tx_last_o
);
   logic          hold_v_q;
   logic [DW-1:0] hold_d_q;
   logic          out_v_q;
   logic [DW-1:0] out_d_q;
   logic          out_l_q;
   logic          out_free;

   assign out_free = !out_v_q || tx_ready_i;
   assign accept_o = !hold_v_q || out_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v_q <= 1'b0;
         hold_d_q <= '0;
         out_v_q  <= 1'b0;
         out_d_q  <= '0;
         out_l_q  <= 1'b0;
      end else begin
         if (out_v_q && tx_ready_i) begin
            out_v_q <= 1'b0;
         end
         if (push_i && accept_o) begin
            if (hold_v_q) begin
               out_v_q <= 1'b1;
               out_d_q <= hold_d_q;
               out_l_q <= 1'b0;
            end
            hold_d_q <= byte_i;
            hold_v_q <= 1'b1;
         end else if (flush_i && accept_o) begin
            if (hold_v_q) begin
               out_v_q <= 1'b1;
               out_d_q <= hold_d_q;
               out_l_q <= 1'b1;
            end
            hold_v_q <= 1'b0;
         end
      end
   end

   assign tx_valid_o = out_v_q;
   assign tx_data_o  = out_d_q;
   assign tx_last_o  = out_l_q;
endmodule

// File: rtl/txring_walk.sv
module txring_walk
   import txring_pkg::*;
#(
   parameter int AW        = 32,
   parameter int MAX_FRAME = 2032,
   parameter int MAX_DESC  = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable_i,
   input  logic          kick_i,
   input  logic          base_we_i,
   input  logic [AW-1:0] base_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [31:0]   mem_wdata_o,
   input  logic          mem_ack_i,
   input  logic [31:0]   mem_rdata_i,
   output logic [31:0]   word_o,
   output logic [1:0]    off_o,
   output logic          push_o,
   output logic          flush_o,
   input  logic          accept_i,
   output logic          ev_txb_o,
   output logic          ev_txf_o,
   output logic          ev_babt_o
);
   localparam int FCW = $clog2(MAX_FRAME + 1);
   localparam int DCW = $clog2(MAX_DESC + 1);
   localparam int LW  = 16;

   walk_st_t       st_q;
   logic [AW-1:0]  cur_q, base_q, ba_q;
   logic [LW-1:0]  flg_q, len_q, rem_q;
   logic [31:0]    word_q;
   logic [FCW-1:0] fc_q;
   logic [DCW-1:0] dcnt_q;
   logic           pend_q, txb_q, txf_q, babt_q;

   logic [LW:0]    room;
   logic [LW-1:0]  hdr_len, eff_len;
   logic           over, start;
   logic [AW-1:0]  nxt_ptr;

   assign room    = (LW+1)'(MAX_FRAME) - (LW+1)'(fc_q);
   assign hdr_len = mem_rdata_i[LW-1:0];
   assign over    = {1'b0, hdr_len} > room;
   assign eff_len = over ? room[LW-1:0] : hdr_len;
   assign start   = (st_q == S_IDLE) && (pend_q || (kick_i && enable_i));
   assign nxt_ptr = flg_q[BIT_WRAP] ? base_q : cur_q + AW'(DESC_BYTES);

   always_comb begin
      mem_req_o = (st_q == S_HDR) || (st_q == S_PTR) || (st_q == S_RD) || (st_q == S_WB);
      mem_we_o  = (st_q == S_WB);
      case (st_q)
         S_PTR:   mem_addr_o = cur_q + AW'(PTR_OFS);
         S_RD:    mem_addr_o = {ba_q[AW-1:2], 2'b00};
         default: mem_addr_o = cur_q;
      endcase
      mem_wdata_o = {flg_q & ~(16'h1 << BIT_OWN), len_q};
   end

   assign word_o  = word_q;
   assign off_o   = ba_q[1:0];
   assign push_o  = (st_q == S_EMIT);
   assign flush_o = (st_q == S_CLOSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cur_q  <= '0;
         base_q <= '0;
         ba_q   <= '0;
         flg_q  <= '0;
         len_q  <= '0;
         rem_q  <= '0;
         word_q <= '0;
         fc_q   <= '0;
         dcnt_q <= '0;
         pend_q <= 1'b0;
         txb_q  <= 1'b0;
         txf_q  <= 1'b0;
         babt_q <= 1'b0;
      end else begin
         txb_q  <= 1'b0;
         txf_q  <= 1'b0;
         babt_q <= 1'b0;
         if (kick_i && enable_i && (st_q != S_IDLE)) begin
            pend_q <= 1'b1;
         end
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  pend_q <= 1'b0;
                  dcnt_q <= '0;
                  st_q   <= S_HDR;
               end
            end
            S_HDR: begin
               if (mem_ack_i) begin
                  flg_q <= mem_rdata_i[31:16];
                  len_q <= hdr_len;
                  if (!mem_rdata_i[16+BIT_OWN]) begin
                     st_q <= S_IDLE;
                  end else begin
                     rem_q  <= eff_len;
                     fc_q   <= fc_q + FCW'(eff_len);
                     babt_q <= over;
                     st_q   <= S_PTR;
                  end
               end
            end
            S_PTR: begin
               if (mem_ack_i) begin
                  ba_q <= mem_rdata_i[AW-1:0];
                  if (rem_q == '0) begin
                     st_q <= flg_q[BIT_EOF] ? S_CLOSE : S_WB;
                  end else begin
                     st_q <= S_RD;
                  end
               end
            end
            S_RD: begin
               if (mem_ack_i) begin
                  word_q <= mem_rdata_i;
                  st_q   <= S_EMIT;
               end
            end
            S_EMIT: begin
               if (accept_i) begin
                  ba_q  <= ba_q + AW'(1);
                  rem_q <= rem_q - LW'(1);
                  if (rem_q == LW'(1)) begin
                     st_q <= flg_q[BIT_EOF] ? S_CLOSE : S_WB;
                  end else if (ba_q[1:0] == 2'b11) begin
                     st_q <= S_RD;
                  end
               end
            end
            S_CLOSE: begin
               if (accept_i) begin
                  fc_q <= '0;
                  st_q <= S_WB;
               end
            end
            S_WB: begin
               if (mem_ack_i) begin
                  txb_q  <= 1'b1;
                  txf_q  <= flg_q[BIT_EOF];
                  dcnt_q <= dcnt_q + DCW'(1);
                  cur_q  <= nxt_ptr;
                  st_q   <= (dcnt_q == DCW'(MAX_DESC - 1)) ? S_IDLE : S_HDR;
               end
            end
            default: st_q <= S_IDLE;
         endcase
         if (base_we_i) begin
            base_q <= base_i & ~AW'(3);
            cur_q  <= base_i & ~AW'(3);
         end
      end
   end

   assign ev_txb_o  = txb_q;
   assign ev_txf_o  = txf_q;
   assign ev_babt_o = babt_q;
endmodule

// File: rtl/txring_dma.sv
module txring_dma #(
   parameter int AW        = 32,
   parameter int MAX_FRAME = 2032,
   parameter int MAX_DESC  = 1024,
   parameter int BIG_END   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable_i,
   input  logic          kick_i,
   input  logic          base_we_i,
   input  logic [AW-1:0] base_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [31:0]   mem_wdata_o,
   input  logic          mem_ack_i,
   input  logic [31:0]   mem_rdata_i,
   output logic          tx_valid_o,
   output logic [7:0]    tx_data_o,
   output logic          tx_last_o,
   input  logic          tx_ready_i,
   output logic          ev_txb_o,
   output logic          ev_txf_o,
   output logic          ev_babt_o
);
   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("txring_dma: AW must lie in 8..32");
      end
      if (MAX_FRAME < 1 || MAX_FRAME > 65535) begin : g_bad_frame
         $error("txring_dma: MAX_FRAME must lie in 1..65535");
      end
      if (MAX_DESC < 1) begin : g_bad_desc
         $error("txring_dma: MAX_DESC must be positive");
      end
   endgenerate

   logic [31:0] word;
   logic [1:0]  off;
   logic [7:0]  lane_byte;
   logic        push, flush, accept;

   txring_walk #(
      .AW(AW), .MAX_FRAME(MAX_FRAME), .MAX_DESC(MAX_DESC)
   ) i_walk (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .kick_i(kick_i),
      .base_we_i(base_we_i), .base_i(base_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
      .word_o(word), .off_o(off), .push_o(push), .flush_o(flush), .accept_i(accept),
      .ev_txb_o(ev_txb_o), .ev_txf_o(ev_txf_o), .ev_babt_o(ev_babt_o)
   );

   txring_lane #(.BIG_END(BIG_END)) i_lane (
      .word_i(word), .off_i(off), .byte_o(lane_byte)
   );

   txring_outq #(.DW(8)) i_outq (
      .clk(clk), .rst_n(rst_n), .push_i(push), .flush_i(flush), .byte_i(lane_byte),
      .accept_o(accept), .tx_ready_i(tx_ready_i), .tx_valid_o(tx_valid_o),
      .tx_data_o(tx_data_o), .tx_last_o(tx_last_o)
   );
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk #(
   parameter int AW        = 32,
   parameter int MAX_FRAME = 2032
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic [31:0]   mem_wdata_o,
   input logic          mem_ack_i,
   input logic          tx_valid_o,
   input logic [7:0]    tx_data_o,
   input logic          tx_last_o,
   input logic          tx_ready_i,
   input logic          ev_txb_o,
   input logic          ev_txf_o,
   input logic          ev_babt_o
);
   logic [16:0] beats_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beats_q <= '0;
      end else if (tx_valid_o && tx_ready_i) begin
         beats_q <= tx_last_o ? '0 : beats_q + 17'd1;
      end
   end

   p_stream_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

   p_wb_owner_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> !mem_wdata_o[31]);

   p_frame_with_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_txf_o |-> ev_txb_o);

   p_frame_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && tx_ready_i) |-> (beats_q < 17'(MAX_FRAME)));

   p_babt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_babt_o |=> !ev_babt_o);
endmodule

bind txring_dma txring_dma_chk #(.AW(AW), .MAX_FRAME(MAX_FRAME)) i_chk (
   .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
   .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
   .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
   .tx_ready_i(tx_ready_i), .ev_txb_o(ev_txb_o), .ev_txf_o(ev_txf_o),
   .ev_babt_o(ev_babt_o)
);

// File: tb/test_txring_dma.sv
`timescale 1ns/1ps
module test_txring_dma;
   localparam int AW = 32;
   localparam int MF = 40;
   localparam int MD = 4;
   localparam logic [31:0] RB = 32'h100;
   localparam logic [15:0] F_OWN = 16'h8000, F_WRAP = 16'h2000, F_EOF = 16'h0800;

   logic clk, rst_n, enable, kick, base_we, mem_req, mem_we, mem_ack;
   logic [AW-1:0] base_v, mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic tx_valid, tx_last, tx_ready, ev_txb, ev_txf, ev_babt;
   logic [7:0] tx_data;

   int n_chk = 0, n_err = 0;
   int n_txb = 0, n_txf = 0, n_babt = 0;
   bit saw_req = 0, got_first = 0, bp_mode = 0;
   logic [31:0] first_addr = 0;
   logic [8:0] exp_q[$];
   logic [31:0] mem [0:511];
   logic bw_en = 0;
   logic [31:0] bw_addr = 0, bw_data = 0;
   logic [7:0] lfsr = 8'h5a;
   longint cyc = 0;
   bit stall_prev = 0;
   logic [8:0] stall_val = 0;

   txring_dma #(.AW(AW), .MAX_FRAME(MF), .MAX_DESC(MD), .BIG_END(1)) i_txring_dma (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .kick_i(kick),
      .base_we_i(base_we), .base_i(base_v),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
      .tx_ready_i(tx_ready), .ev_txb_o(ev_txb), .ev_txf_o(ev_txf), .ev_babt_o(ev_babt)
   );

   initial clk = 0;
   always #4 clk = ~clk;

   // memory model: one acknowledge per request, one cycle later
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[10:2]];
         end
      end
      if (bw_en) mem[bw_addr[10:2]] <= bw_data;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready <= bp_mode ? lfsr[0] : 1'b1;
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // monitor: scoreboard compare, stall stability, event counters
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
      if (rst_n) begin
         if (mem_req) saw_req = 1;
         if (mem_req && !got_first) begin got_first = 1; first_addr = mem_addr; end
         n_txb += int'(ev_txb); n_txf += int'(ev_txf); n_babt += int'(ev_babt);
         if (stall_prev)
            chk(tx_valid && ({tx_last, tx_data} == stall_val), "R12", "held beat",
                {tx_valid, tx_last, tx_data}, {1'b1, stall_val});
         stall_prev = tx_valid && !tx_ready;
         stall_val  = {tx_last, tx_data};
         if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
               chk(0, "R12", "unexpected beat", {tx_last, tx_data}, 0);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk({tx_last, tx_data} == e, "R5", "stream beat {last,data}",
                   {tx_last, tx_data}, e);
            end
         end
      end
   end

   task automatic bwrite(input logic [31:0] a, input logic [31:0] d);
      bw_addr = a; bw_data = d; bw_en = 1;
      @(posedge clk); #1 bw_en = 0;
   endtask

   function automatic logic [7:0] rbyte(input logic [31:0] a);
      return mem[a[10:2]][8*(3-int'(a[1:0])) +: 8];
   endfunction

   task automatic put_desc(input int slot, input logic [15:0] fl, input logic [15:0] ln,
                           input logic [31:0] ba);
      bwrite(RB + 32'(8*slot), {fl, ln});
      bwrite(RB + 32'(8*slot) + 32'd4, ba);
   endtask

   task automatic fill(input logic [31:0] a, input int n, input int seed);
      for (int k = 0; k < n; k++) begin
         logic [31:0] w;
         logic [31:0] ak;
         ak = a + 32'(k);
         w = mem[ak[10:2]];
         w[8*(3-int'(ak[1:0])) +: 8] = 8'(seed + 7*k);
         bwrite(ak, w);
      end
   endtask

   // driver side of the scoreboard
   task automatic expect_bytes(input logic [31:0] a, input int n, input bit eof);
      for (int k = 0; k < n; k++)
         exp_q.push_back({(eof && k == n-1), rbyte(a + 32'(k))});
   endtask

   task automatic clr_ev();
      n_txb = 0; n_txf = 0; n_babt = 0; saw_req = 0; got_first = 0;
   endtask

   task automatic do_kick();
      @(negedge clk); kick = 1;
      @(negedge clk); kick = 0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      int spin = 0;
      while (quiet < 40 && spin < 6000) begin
         @(negedge clk);
         spin++;
         if (mem_req || tx_valid) quiet = 0; else quiet++;
      end
      chk(spin < 6000, "R12", "walk finished", spin, 6000);
   endtask

   initial begin
      rst_n = 0; enable = 0; kick = 0; base_we = 0; base_v = '0;
      for (int i = 0; i < 512; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (5) @(negedge clk);
      // R1: quiet after reset
      chk(!mem_req, "R1", "mem_req after reset", mem_req, 0);
      chk(!tx_valid, "R1", "tx_valid after reset", tx_valid, 0);
      chk(n_txb == 0 && n_txf == 0 && n_babt == 0, "R1", "events after reset",
          n_txb + n_txf + n_babt, 0);

      // R8: kick ignored while disabled
      put_desc(0, F_OWN | F_EOF, 16'd6, 32'h400);
      fill(32'h400, 6, 8'h11);
      clr_ev();
      do_kick();
      repeat (30) @(negedge clk);
      chk(!saw_req, "R8", "memory activity with enable low", saw_req, 0);
      chk(n_txb == 0, "R8", "buffer events with enable low", n_txb, 0);

      // R10, R2, R5, R6: base write with low bits, single-buffer frame
      @(negedge clk); base_v = 32'h103; base_we = 1;
      @(negedge clk); base_we = 0;
      enable = 1;
      expect_bytes(32'h400, 6, 1);
      clr_ev();
      do_kick();
      wait_idle();
      chk(first_addr == RB, "R10", "first fetch address", first_addr, RB);
      chk(exp_q.size() == 0, "R2", "bytes left", exp_q.size(), 0);
      chk(n_txb == 1 && n_txf == 1, "R6", "txb/txf", {n_txb, n_txf}, {32'd1, 32'd1});
      chk(mem[RB[10:2]] == {F_EOF, 16'd6}, "R6", "written-back word",
          mem[RB[10:2]], {F_EOF, 16'd6});

      // R2, R12: three-buffer frame, unaligned buffers, backpressure
      fill(32'h441, 3, 8'h20); fill(32'h482, 7, 8'h40); fill(32'h4c3, 5, 8'h60);
      put_desc(1, F_OWN, 16'd3, 32'h441);
      put_desc(2, F_OWN, 16'd7, 32'h482);
      put_desc(3, F_OWN | F_EOF, 16'd5, 32'h4c3);
      expect_bytes(32'h441, 3, 0); expect_bytes(32'h482, 7, 0); expect_bytes(32'h4c3, 5, 1);
      bp_mode = 1;
      clr_ev();
      do_kick();
      wait_idle();
      bp_mode = 0;
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R12", "bytes left under backpressure", exp_q.size(), 0);
      chk(n_txb == 3, "R6", "txb for three buffers", n_txb, 3);
      chk(n_txf == 1, "R5", "txf for one frame", n_txf, 1);

      // R3: slot 4 not owned; pointer stays
      clr_ev();
      do_kick();
      wait_idle();
      chk(n_txb == 0, "R3", "no buffer consumed", n_txb, 0);
      chk(first_addr == RB + 32'd32, "R3", "fetched slot4", first_addr, RB + 32'd32);
      fill(32'h500, 4, 8'h80);
      put_desc(4, F_OWN | F_EOF, 16'd4, 32'h500);
      expect_bytes(32'h500, 4, 1);
      clr_ev();
      do_kick();
      wait_idle();
      chk(first_addr == RB + 32'd32, "R3", "refetch same slot", first_addr, RB + 32'd32);
      chk(exp_q.size() == 0 && n_txf == 1, "R3", "frame from slot4", exp_q.size(), 0);

      // R7: cap at 40 bytes, then count restarts
      fill(32'h540, 30, 8'h01); fill(32'h580, 20, 8'h91); fill(32'h5c0, 8, 8'hc3);
      put_desc(5, F_OWN, 16'd30, 32'h540);
      put_desc(6, F_OWN | F_EOF, 16'd20, 32'h580);
      put_desc(7, F_OWN | F_EOF | F_WRAP, 16'd8, 32'h5c0);
      expect_bytes(32'h540, 30, 0); expect_bytes(32'h580, 10, 1); expect_bytes(32'h5c0, 8, 1);
      clr_ev();
      do_kick();
      wait_idle();
      chk(exp_q.size() == 0, "R7", "capped stream", exp_q.size(), 0);
      chk(n_babt == 1, "R7", "truncation pulses", n_babt, 1);
      chk(n_txf == 2 && n_txb == 3, "R7", "txf/txb", {n_txf, n_txb}, {32'd2, 32'd3});
      chk(mem[(RB + 32'd48) >> 2] == {F_EOF, 16'd20}, "R6", "len kept in write-back",
          mem[(RB + 32'd48) >> 2], {F_EOF, 16'd20});

      // R4: wrap back to slot 0
      fill(32'h600, 2, 8'hd0);
      put_desc(0, F_OWN | F_EOF, 16'd2, 32'h600);
      expect_bytes(32'h600, 2, 1);
      clr_ev();
      do_kick();
      wait_idle();
      chk(first_addr == RB, "R4", "fetch after wrap", first_addr, RB);
      chk(exp_q.size() == 0 && n_txb == 1, "R4", "wrapped frame", n_txb, 1);

      // R9: at most 4 descriptors per kick
      for (int s = 1; s <= 6; s++) begin
         fill(32'h640 + 32'(4*s), 1, 8'h30 + s);
         put_desc(s, F_OWN | F_EOF, 16'd1, 32'h640 + 32'(4*s));
      end
      for (int s = 1; s <= 4; s++) expect_bytes(32'h640 + 32'(4*s), 1, 1);
      clr_ev();
      do_kick();
      wait_idle();
      chk(n_txb == MD, "R9", "descriptors in one kick", n_txb, MD);
      chk(exp_q.size() == 0, "R9", "bytes of first kick", exp_q.size(), 0);
      for (int s = 5; s <= 6; s++) expect_bytes(32'h640 + 32'(4*s), 1, 1);
      clr_ev();
      do_kick();
      wait_idle();
      chk(n_txb == 2, "R9", "descriptors in second kick", n_txb, 2);
      chk(exp_q.size() == 0, "R9", "bytes of second kick", exp_q.size(), 0);

      // R11: frame open across kicks
      fill(32'h700, 3, 8'h55);
      put_desc(7, F_OWN | F_WRAP, 16'd3, 32'h700);
      expect_bytes(32'h700, 3, 0);
      clr_ev();
      do_kick();
      wait_idle();
      chk(exp_q.size() == 1, "R11", "one byte held back", exp_q.size(), 1);
      chk(n_txf == 0 && n_txb == 1, "R11", "no frame done", n_txf, 0);
      fill(32'h740, 2, 8'h66);
      put_desc(0, F_OWN | F_EOF, 16'd2, 32'h740);
      expect_bytes(32'h740, 2, 1);
      clr_ev();
      do_kick();
      wait_idle();
      chk(exp_q.size() == 0 && n_txf == 1, "R11", "frame closed on next kick",
          exp_q.size(), 0);

      // R5: zero-length closing descriptor
      fill(32'h780, 3, 8'h77);
      put_desc(1, F_OWN, 16'd3, 32'h780);
      put_desc(2, F_OWN | F_EOF, 16'd0, 32'h7c0);
      expect_bytes(32'h780, 3, 1);
      clr_ev();
      do_kick();
      wait_idle();
      chk(exp_q.size() == 0, "R5", "marker on previous byte", exp_q.size(), 0);
      chk(n_txb == 2 && n_txf == 1, "R5", "events for empty closer",
          {n_txb, n_txf}, {32'd2, 32'd1});

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule